// File: doc/BRIEF.md
# Boot-Block Top-Swap Address Remapper

This block sits on the path from a host's physical address to a flash decoder. When its swap control is set, it exchanges the topmost boot-block-sized window just below the 4 GiB boundary with the window of the same size directly beneath it. A host can then fetch its reset vector from a backup copy of the boot block without rewriting the flash image. When the control is clear, addresses pass through unchanged. The translation is combinational. Host addresses move through a valid/ready pair that adds no buffering. The output side's ready goes straight back to the input side, and `out_valid` follows `in_valid` in the same cycle. Back-pressure therefore stalls the host directly, and a held address keeps its translation for as long as it is stalled.

A small register interface gives access to three things. The first is a lock bit that can only be set and is cleared by a normal reset. The second is the swap bit, which models a battery-backed bit. It is cleared only by the separate backup-domain reset and survives a normal reset. The third is a read-only status word holding the decoded size code and an error flag for a bad size strap. The window size is 64 KiB unless two conditions hold: the platform enables variable sizing, and the boot-device field selects SPI. In that case a 3-bit strap picks 64, 128 or 256 KiB.

Top module: `bootswap_remap`

## Requirements
- R1: While the swap bit is 0, `flash_addr` equals `host_addr` for every address.
- R2: While the swap bit is 1 and the window size is S, an address in [4G-S, 4G-1] maps to itself minus S. An address in [4G-2S, 4G-S-1] maps to itself plus S. Every other address passes unchanged. This is the same as inverting address bit log2(S) inside the top 2S bytes.
- R3: The size is 64 KiB unless `var_size_en` is 1 and `boot_dev` equals 2'b11 (SPI). When both hold, `strap_size` values 0, 1 and 2 select 64, 128 and 256 KiB, reported as size codes 0, 1 and 2.
- R4: With variable sizing in effect, a `strap_size` of 3 or more sets the error flag (status bit 4) and falls back to 64 KiB, size code 0. Otherwise the flag reads 0.
- R5: A write to register address 1 loads `reg_wdata` into the swap bit from the next cycle on. The write is ignored while the lock bit is set, and both the swap read-back and `flash_addr` keep their old value.
- R6: A write of 1 to register address 0 sets the lock bit. A write of 0 does not clear it. Only a normal reset (`rst_n` low) clears it.
- R7: A normal reset leaves the swap bit unchanged. Only `bkp_rst_n` low clears it.
- R8: A read with `reg_rd` high raises `reg_rvalid` in the next cycle, with `reg_rdata` holding the value. Address 0 returns {7'b0, lock}. Address 1 returns {7'b0, swap}. Address 2 returns {3'b0, error, size code[1:0], lock, swap}. Address 3 returns 0. `reg_rvalid` is low in the cycle after a cycle with no read.
- R9: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. A change of swap or size reaches `flash_addr` with no clock edge, apart from the register update itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Normal reset, active low, asynchronous |
| bkp_rst_n | input | 1 | Backup-domain reset, active low; clears the swap bit only |
| var_size_en | input | 1 | Platform supports a strap-selected window size |
| boot_dev | input | 2 | Boot-device field; 2'b11 means SPI |
| strap_size | input | 3 | Size strap field (bits 31:29 of strap word 0) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 1 | Write data bit |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| reg_rdata | output | 8 | Read data |
| in_valid | input | 1 | Host address valid |
| in_ready | output | 1 | Block can take the host address |
| host_addr | input | 32 | Host physical address |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Flash decoder can take the address |
| flash_addr | output | 32 | Translated address |

## Verification
The translation and the handshake have no register in their path. The bench drives the address and sizing pins, waits one time step and compares within the same clock phase. A register write takes effect at the next rising edge. The bench checks `flash_addr` once just before that edge, where the old mapping must still hold, and again after it, where the new mapping must hold. A read is issued in one cycle and its data is sampled at the following falling edge, where `reg_rvalid` must be high. Reset behaviour is checked after each reset pulse has been released and a clock edge has passed.

// File: rtl/bootswap_pkg.sv
package bootswap_pkg;
  // Size code width; the block supports at most four window sizes.
  localparam int CODE_W = 2;

  typedef logic [CODE_W-1:0] size_code_t;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_SWAP = 2'd1,
    RA_STAT = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam logic [1:0] BOOT_SPI = 2'b11;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       err;
    size_code_t code;
    logic       lock;
    logic       swap;
  } status_t;
endpackage

// File: rtl/bsw_size_sel.sv
module bsw_size_sel
  import bootswap_pkg::*;
#(
  parameter int STRAP_W   = 3,
  parameter int NUM_SIZES = 3
) (
  input  logic               var_en_i,
  input  logic [1:0]         boot_dev_i,
  input  logic [STRAP_W-1:0] strap_i,
  output size_code_t         code_o,
  output logic               err_o
);
  localparam logic [STRAP_W-1:0] LIMIT = STRAP_W'(NUM_SIZES);

  logic applies;
  logic bad;

  // Strap sizing is honoured only on capable platforms booting from SPI.
  assign applies = var_en_i && (boot_dev_i == BOOT_SPI);
  assign bad     = (strap_i >= LIMIT);

  always_comb begin
    code_o = '0;
    err_o  = 1'b0;
    if (applies) begin
      if (bad) err_o = 1'b1;
      else     code_o = CODE_W'(strap_i);
    end
  end
endmodule

// File: rtl/bsw_regs.sv
module bsw_regs
  import bootswap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bkp_rst_n,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [1:0] addr_i,
  input  logic       wdata_i,
  input  size_code_t code_i,
  input  logic       err_i,
  output logic       swap_o,
  output logic       lock_o,
  output logic       rvalid_o,
  output logic [7:0] rdata_o
);
  logic    swap_q;
  logic    lock_q;
  status_t stat;
  logic [7:0] rd_mux;

  // Battery-backed swap bit: only the backup-domain reset clears it.
  always_ff @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n)
      swap_q <= 1'b0;
    else if (rst_n && wr_i && (addr_i == RA_SWAP) && !lock_q)
      swap_q <= wdata_i;
  end

  // Lock: set-only until the next normal reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= 1'b0;
    else if (wr_i && (addr_i == RA_CTRL) && wdata_i)
      lock_q <= 1'b1;
  end

  always_comb begin
    stat      = '0;
    stat.swap = swap_q;
    stat.lock = lock_q;
    stat.code = code_i;
    stat.err  = err_i;
    case (addr_i)
      RA_CTRL: rd_mux = {7'd0, lock_q};
      RA_SWAP: rd_mux = {7'd0, swap_q};
      RA_STAT: rd_mux = stat;
      default: rd_mux = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= 8'd0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_mux;
    end
  end

  assign swap_o = swap_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/bsw_xlate.sv
module bsw_xlate
  import bootswap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_LOG2 = 16,
  parameter int NUM_SIZES = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              swap_i,
  input  size_code_t        code_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0]    cand [NUM_SIZES];
  logic [NUM_SIZES-1:0] hit;

  // One candidate per window size: flip bit log2(size) inside the top 2*size.
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int FLIP = BASE_LOG2 + g;
    assign hit[g]  = &addr_i[ADDR_W-1:FLIP+1];
    assign cand[g] = addr_i ^ (ADDR_W'(1) << FLIP);
  end

  always_comb begin
    addr_o = addr_i;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (swap_i && (code_i == CODE_W'(k)) && hit[k]) addr_o = cand[k];
    end
  end
endmodule

// File: rtl/bootswap_remap.sv
module bootswap_remap
  import bootswap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_LOG2 = 16,
  parameter int NUM_SIZES = 3,
  parameter int STRAP_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bkp_rst_n,
  input  logic               var_size_en,
  input  logic [1:0]         boot_dev,
  input  logic [STRAP_W-1:0] strap_size,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wdata,
  output logic               reg_rvalid,
  output logic [7:0]         reg_rdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  host_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  flash_addr
);
  size_code_t size_code;
  logic       strap_err;
  logic       top_swap;
  logic       top_lock;

  bsw_size_sel #(
    .STRAP_W  (STRAP_W),
    .NUM_SIZES(NUM_SIZES)
  ) u_size (
    .var_en_i  (var_size_en),
    .boot_dev_i(boot_dev),
    .strap_i   (strap_size),
    .code_o    (size_code),
    .err_o     (strap_err)
  );

  bsw_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bkp_rst_n(bkp_rst_n),
    .wr_i     (reg_wr),
    .rd_i     (reg_rd),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .code_i   (size_code),
    .err_i    (strap_err),
    .swap_o   (top_swap),
    .lock_o   (top_lock),
    .rvalid_o (reg_rvalid),
    .rdata_o  (reg_rdata)
  );

  bsw_xlate #(
    .ADDR_W   (ADDR_W),
    .BASE_LOG2(BASE_LOG2),
    .NUM_SIZES(NUM_SIZES)
  ) u_xlate (
    .addr_i(host_addr),
    .swap_i(top_swap),
    .code_i(size_code),
    .addr_o(flash_addr)
  );

  // Zero-latency pass-through handshake.
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker
  import bootswap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SIZES = 3,
  parameter int STRAP_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bkp_rst_n,
  input logic               var_size_en,
  input logic [1:0]         boot_dev,
  input logic [STRAP_W-1:0] strap_size,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [1:0]         reg_addr,
  input logic               reg_rvalid,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [ADDR_W-1:0]  flash_addr,
  input logic               top_swap,
  input logic               top_lock,
  input size_code_t         size_code,
  input logic               strap_err
);
  logic spi_var;
  assign spi_var = var_size_en && (boot_dev == BOOT_SPI);

  AST_PASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    !top_swap |-> (flash_addr == host_addr)); // R1
  AST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    $countones(flash_addr ^ host_addr) <= 1); // R2
  AST_DEFAULT_SIZE: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    !spi_var |-> (size_code == '0 && !strap_err)); // R3
  AST_BAD_STRAP: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    (spi_var && strap_size >= STRAP_W'(NUM_SIZES)) |-> (size_code == '0 && strap_err)); // R4
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    (top_lock && reg_wr && reg_addr == RA_SWAP) |=> $stable(top_swap)); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    top_lock |=> top_lock); // R6
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    reg_rd |=> reg_rvalid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    !reg_rd |=> !reg_rvalid); // R8
  AST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n || !bkp_rst_n)
    (out_valid == in_valid) && (in_ready == out_ready)); // R9
endmodule

bind bootswap_remap bsw_checker #(
  .ADDR_W   (ADDR_W),
  .NUM_SIZES(NUM_SIZES),
  .STRAP_W  (STRAP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bkp_rst_n  (bkp_rst_n),
  .var_size_en(var_size_en),
  .boot_dev   (boot_dev),
  .strap_size (strap_size),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_rvalid (reg_rvalid),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .host_addr  (host_addr),
  .flash_addr (flash_addr),
  .top_swap   (top_swap),
  .top_lock   (top_lock),
  .size_code  (size_code),
  .strap_err  (strap_err)
);

// File: tb/tb_bootswap_remap.sv
module tb_bootswap_remap;
  logic        clk = 1'b0;
  logic        rst_n, bkp_rst_n;
  logic        var_size_en;
  logic [1:0]  boot_dev;
  logic [2:0]  strap_size;
  logic        reg_wr, reg_rd, reg_wdata;
  logic [1:0]  reg_addr;
  logic        reg_rvalid;
  logic [7:0]  reg_rdata;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] host_addr, flash_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit m_swap   = 0;
  bit m_lock   = 0;

  always #5 clk = ~clk;

  bootswap_remap dut (
    .clk(clk), .rst_n(rst_n), .bkp_rst_n(bkp_rst_n),
    .var_size_en(var_size_en), .boot_dev(boot_dev), .strap_size(strap_size),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .host_addr(host_addr),
    .out_valid(out_valid), .out_ready(out_ready), .flash_addr(flash_addr)
  );

  function automatic int m_code();
    if (var_size_en && boot_dev == 2'b11 && strap_size < 3) return int'(strap_size);
    return 0;
  endfunction

  function automatic bit m_err();
    return var_size_en && boot_dev == 2'b11 && strap_size >= 3;
  endfunction

  function automatic logic [31:0] m_map(logic [31:0] a, bit sw, int code);
    longint unsigned sz, top, ua;
    sz  = 64'h1_0000 << code;
    top = 64'h1_0000_0000;
    ua  = {32'd0, a};
    if (sw && ua >= top - 2 * sz) begin
      if (ua >= top - sz) ua = ua - sz;
      else                ua = ua + sz;
    end
    return ua[31:0];
  endfunction

  function automatic logic [7:0] m_stat();
    return {3'b0, m_err(), 2'(m_code()), m_lock, m_swap};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_addr(string req, logic [31:0] a);
    host_addr = a;
    #1;
    check(req, flash_addr, m_map(a, m_swap, m_code()));
  endtask

  task automatic wr(logic [1:0] a, logic d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0 && d) m_lock = 1;
    if (a == 2'd1 && !m_lock) m_swap = d;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, {31'd0, reg_rvalid}, 32'd1);
    check(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic strap(bit v, logic [1:0] b, logic [2:0] s);
    var_size_en = v; boot_dev = b; strap_size = s;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; bkp_rst_n = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    in_valid = 0; out_ready = 0; host_addr = 0;
    strap(0, 2'b00, 3'd0);
    repeat (3) @(negedge clk);
    bkp_rst_n = 1;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state
    check("R8 reset rvalid", {31'd0, reg_rvalid}, 32'd0);
    rd("R8 reset status", 2'd2, 8'h00);
    rd("R8 unused addr", 2'd3, 8'h00);
    chk_addr("R1 top pass", 32'hFFFF_FFF0);
    chk_addr("R1 low pass", 32'h0000_1234);
    chk_addr("R1 bb1 pass", 32'hFFFE_0000);

    // Swap with default size
    wr(2'd1, 1'b1);
    rd("R5 swap readback", 2'd1, 8'h01);
    chk_addr("R2 top->low", 32'hFFFF_0010);
    check("R2 top->low value", flash_addr, 32'hFFFE_0010);
    chk_addr("R2 low->top", 32'hFFFE_1234);
    check("R2 low->top value", flash_addr, 32'hFFFF_1234);
    chk_addr("R2 below window", 32'hFFFD_FFFF);

    // Size selection
    strap(1, 2'b11, 3'd1);
    chk_addr("R3 128K", 32'hFFFF_0000);
    check("R3 128K value", flash_addr, 32'hFFFD_0000);
    chk_addr("R3 128K low", 32'hFFFC_0000);
    rd("R3 code1 status", 2'd2, m_stat());
    strap(1, 2'b11, 3'd2);
    chk_addr("R3 256K", 32'hFFFF_8000);
    check("R3 256K value", flash_addr, 32'hFFFB_8000);
    strap(1, 2'b10, 3'd2);
    chk_addr("R3 non-SPI default", 32'hFFFF_8000);
    strap(0, 2'b11, 3'd2);
    chk_addr("R3 no var default", 32'hFFFF_8000);
    rd("R3 default status", 2'd2, m_stat());

    // Bad strap
    strap(1, 2'b11, 3'd5);
    chk_addr("R4 fallback", 32'hFFFF_4000);
    check("R4 fallback value", flash_addr, 32'hFFFE_4000);
    rd("R4 err flag", 2'd2, 8'h11);
    strap(1, 2'b11, 3'd3);
    rd("R4 err flag 3", 2'd2, 8'h11);
    strap(0, 2'b00, 3'd0);

    // Next-cycle effect and handshake
    host_addr = 32'hFFFF_0020;
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 1'b0;
    #1 check("R9 before edge", flash_addr, 32'hFFFE_0020);
    @(negedge clk);
    reg_wr = 0; m_swap = 0;
    check("R9 after edge", flash_addr, 32'hFFFF_0020);
    in_valid = 1; out_ready = 0; #1;
    check("R9 valid", {31'd0, out_valid}, 32'd1);
    check("R9 ready low", {31'd0, in_ready}, 32'd0);
    in_valid = 0; out_ready = 1; #1;
    check("R9 valid low", {31'd0, out_valid}, 32'd0);
    check("R9 ready", {31'd0, in_ready}, 32'd1);
    wr(2'd1, 1'b1);

    // Lock
    wr(2'd0, 1'b1);
    rd("R6 lock set", 2'd0, 8'h01);
    wr(2'd1, 1'b0);
    rd("R5 write ignored", 2'd1, 8'h01);
    chk_addr("R5 mapping kept", 32'hFFFF_0040);
    check("R5 mapping value", flash_addr, 32'hFFFE_0040);
    wr(2'd0, 1'b0);
    rd("R6 lock not cleared", 2'd0, 8'h01);

    // Normal reset keeps swap, clears lock
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; m_lock = 0;
    @(negedge clk);
    rd("R7 swap kept", 2'd2, 8'h01);
    rd("R6 lock cleared", 2'd0, 8'h00);
    chk_addr("R7 mapping kept", 32'hFFFF_0000);
    @(negedge clk); rst_n = 0; bkp_rst_n = 0;
    @(negedge clk); bkp_rst_n = 1;
    @(negedge clk); rst_n = 1; m_swap = 0;
    @(negedge clk);
    rd("R7 backup clears", 2'd1, 8'h00);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) wr(2'd1, 1'($urandom_range(0, 1)));
      if (sel == 1 && $urandom_range(0, 7) == 0) wr(2'd0, 1'b1);
      if (sel == 2) begin
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; m_lock = 0;
      end
      strap(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)));
      if ($urandom_range(0, 3) == 0) chk_addr("R2 random", $urandom());
      else chk_addr("R2 random top", 32'hFFF8_0000 | ($urandom() & 32'h0007_FFFF));
      if (sel == 3) rd("R8 random status", 2'd2, m_stat());
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule